// File: doc/BRIEF.md
# Serial Interrupt Bus Host Controller

This block is the host-side master of a single-wire, open-drain serial interrupt bus. It drives the Start frame that opens each bus cycle. It then steps through a fixed train of three-clock data frames, one frame per interrupt source, and samples the line once per frame. It closes the cycle with a Stop frame, and the width of that Stop frame tells every agent which mode the bus is in for the next idle period.

The sampled levels are turned into one vector of request bits, where 1 always means "requested". The sixteen legacy ISA frames are active-high on the wire. The system-management, channel-check and four PCI interrupt frames are active-low. Three ISA positions carry sources that exist only inside the host, so their serial values are dropped. A second ISA vector is passed on to a disk-controller path, and it excludes the two disk channel frames. The whole vector updates once per bus cycle, and a strobe marks that update.

In continuous mode only the host opens a cycle, after a fixed idle gap. In quiet mode a peripheral may also request a cycle by pulling the line low for one clock while the bus is idle.

Top module: `sirq_host`

## Requirements
- R1: After the idle gap, the host drives the line low for 4, 6, 8 or 8 clocks for `start_sel_i` = 0, 1, 2 or 3. It then drives the line high for one clock and releases it. The idle gap is `GAP_CLKS` = 16 clocks, and the first cycle after reset follows this same gap.
- R2: One clock of turnaround follows the Start frame. After it come 22 data frames of three clocks each. The host releases the line during every data frame and samples it only on the first clock of each frame. Frame k for k = 0..15 is ISA IRQk, frame 16 is system management, frame 17 is channel check, and frames 18..21 are PCI INTA..INTD.
- R3: For ISA frames that are not ignored, a high sample sets the request bit `irq_req_o[k]` and a low sample clears it.
- R4: For frames 16..21, a low sample sets the request bit and a high sample clears it.
- R5: Bits 0, 8 and 13 of `irq_req_o` stay 0 whatever the serial stream carries.
- R6: For bits 0..13, `isa_fwd_o` equals `irq_req_o[15:0]`. Bits 14 and 15 of `isa_fwd_o` are always 0.
- R7: After the last frame, the host drives the line low for 2 clocks when `stop_long_i` = 0 and for 3 clocks when `stop_long_i` = 1. It then drives the line high for one clock and releases it.
- R8: A 3-clock Stop frame selects continuous mode (`cont_mode_o` = 1). In this mode a low driven by a peripheral during idle is ignored, and the next Start frame begins only when the gap expires.
- R9: A 2-clock Stop frame selects quiet mode (`cont_mode_o` = 0). In this mode a low seen during idle makes the host drive a full-width Start frame from the next clock onwards.
- R10: `irq_req_o` and `isa_fwd_o` change only in the clock that follows the last Stop-low clock. `cyc_valid_o` is high for exactly that one clock.
- R11: Under reset, every request output and `cyc_valid_o` are 0, the line is released, and the bus is in continuous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_long_i | input | 1 | 1 selects a 3-clock Stop frame (continuous), 0 a 2-clock one (quiet) |
| start_sel_i | input | 2 | Start-frame low width: 0=4, 1=6, 2 or 3 = 8 clocks |
| sirq_io | inout | 1 | Open-drain serial interrupt line, needs an external pull-up |
| irq_req_o | output | 22 | Decoded request bits, 1 = requested, indexed by frame |
| isa_fwd_o | output | 16 | ISA request bits for the disk-controller path, bits 14 and 15 held at 0 |
| cyc_valid_o | output | 1 | One-clock strobe when the request vectors update |
| cont_mode_o | output | 1 | Current bus mode, 1 = continuous, 0 = quiet |

## Verification
The assertions take `start_sel_i` to be constant while a Start frame is driven. They take `stop_long_i` to be constant between the last data frame and the end of the Stop frame. They also take no other agent to drive the line during the Start and Stop frames. The stimulus changes both configuration inputs only in the Stop-high clock, when the host is itself driving the line. The peripheral model drives only during data frames, or during idle as a single one-clock low pulse. Turnaround glitches go only on frames that read high, so they can test the sampling point without causing a drive conflict.

// File: rtl/sirq_host_pkg.sv
package sirq_host_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SLOW,
        S_SHI,
        S_STA,
        S_FRM,
        S_PLOW,
        S_PHI
    } sirq_state_e;

    // Start-frame low width from the two-bit selector
    function automatic logic [3:0] start_len(input logic [1:0] sel);
        case (sel)
            2'd0:    start_len = 4'd4;
            2'd1:    start_len = 4'd6;
            default: start_len = 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/sirq_frame_seq.sv
module sirq_frame_seq
    import sirq_host_pkg::*;
#(
    parameter int GAP_CLKS   = 16,
    parameter int NUM_FRAMES = 22,
    parameter int FRAME_W    = 5,
    parameter int CNT_W      = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_i,
    input  logic               stop_long_i,
    input  logic [1:0]         start_sel_i,
    output logic               drv_en_o,
    output logic               drv_val_o,
    output logic               samp_o,
    output logic [FRAME_W-1:0] idx_o,
    output logic               commit_o,
    output logic               cont_mode_o
);

    typedef struct packed {
        sirq_state_e        state;
        logic [CNT_W-1:0]   cnt;
        logic [1:0]         phase;
        logic [FRAME_W-1:0] frame;
        logic               stop_long;
        logic               cont;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        commit_o = 1'b0;
        unique case (r_q.state)
            S_IDLE: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if ((!r_q.cont && !line_i) || (r_q.cnt == CNT_W'(GAP_CLKS - 1))) begin
                    r_d.state = S_SLOW;
                    r_d.cnt   = '0;
                end
            end
            S_SLOW: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CNT_W'(start_len(start_sel_i) - 4'd1)) begin
                    r_d.state = S_SHI;
                    r_d.cnt   = '0;
                end
            end
            S_SHI: r_d.state = S_STA;
            S_STA: begin
                r_d.state = S_FRM;
                r_d.phase = 2'd0;
                r_d.frame = '0;
            end
            S_FRM: begin
                if (r_q.phase == 2'd2) begin
                    r_d.phase = 2'd0;
                    if (r_q.frame == FRAME_W'(NUM_FRAMES - 1)) begin
                        r_d.state     = S_PLOW;
                        r_d.cnt       = '0;
                        r_d.stop_long = stop_long_i;
                    end else begin
                        r_d.frame = r_q.frame + 1'b1;
                    end
                end else begin
                    r_d.phase = r_q.phase + 1'b1;
                end
            end
            S_PLOW: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == (r_q.stop_long ? CNT_W'(2) : CNT_W'(1))) begin
                    r_d.state = S_PHI;
                    r_d.cnt   = '0;
                    r_d.cont  = r_q.stop_long;
                    commit_o  = 1'b1;
                end
            end
            S_PHI: begin
                r_d.state = S_IDLE;
                r_d.cnt   = '0;
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= S_IDLE;
            r_q.cnt       <= '0;
            r_q.phase     <= 2'd0;
            r_q.frame     <= '0;
            r_q.stop_long <= 1'b0;
            r_q.cont      <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign drv_en_o    = (r_q.state == S_SLOW) || (r_q.state == S_SHI) ||
                         (r_q.state == S_PLOW) || (r_q.state == S_PHI);
    assign drv_val_o   = (r_q.state == S_SHI) || (r_q.state == S_PHI);
    assign samp_o      = (r_q.state == S_FRM) && (r_q.phase == 2'd0);
    assign idx_o       = r_q.frame;
    assign cont_mode_o = r_q.cont;

    AST_START_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_SHI) |-> ($past(r_q.state) == S_SLOW &&
         $past(r_q.cnt) == CNT_W'(start_len($past(start_sel_i)) - 4'd1))); // R1
    AST_STOP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_PHI) |-> ($past(r_q.state) == S_PLOW &&
         $past(r_q.cnt) == (r_q.stop_long ? CNT_W'(2) : CNT_W'(1)))); // R7
    AST_SAMPLE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        samp_o |=> !samp_o); // R2
    AST_COMMIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o); // R10
    AST_MODE_FOLLOWS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> (cont_mode_o == $past(r_q.stop_long))); // R8

endmodule

// File: rtl/sirq_level_decode.sv
module sirq_level_decode #(
    parameter int                NUM_ISA     = 16,
    parameter int                NUM_LOW     = 6,
    parameter logic [NUM_ISA-1:0] IGNORE_MASK = 16'h2101,
    parameter int                FRAME_W     = 5,
    localparam int               NUM_FRAMES  = NUM_ISA + NUM_LOW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_i,
    input  logic                  samp_i,
    input  logic [FRAME_W-1:0]    idx_i,
    input  logic                  commit_i,
    output logic [NUM_FRAMES-1:0] lvl_o,
    output logic                  valid_o
);

    typedef struct packed {
        logic [NUM_FRAMES-1:0] shadow;
        logic [NUM_FRAMES-1:0] lvl;
        logic                  valid;
    } dec_t;

    dec_t r_d, r_q;
    logic [NUM_FRAMES-1:0] decoded;

    // Per-frame polarity and ignore handling
    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_pol
        if (g < NUM_ISA) begin : g_isa
            assign decoded[g] = r_q.shadow[g] & ~IGNORE_MASK[g];
        end else begin : g_low
            assign decoded[g] = ~r_q.shadow[g];
        end
    end

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (samp_i) begin
            r_d.shadow[idx_i] = line_i;
        end
        if (commit_i) begin
            r_d.lvl   = decoded;
            r_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign lvl_o   = r_q.lvl;
    assign valid_o = r_q.valid;

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(lvl_o)); // R10
    AST_VALID_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> valid_o); // R10
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        samp_i |-> (idx_i < FRAME_W'(NUM_FRAMES))); // R2

endmodule

// File: rtl/sirq_host.sv
module sirq_host
    import sirq_host_pkg::*;
#(
    parameter int                 GAP_CLKS    = 16,
    parameter int                 NUM_ISA     = 16,
    parameter int                 NUM_LOW     = 6,
    parameter logic [NUM_ISA-1:0] IGNORE_MASK = 16'h2101,
    parameter logic [NUM_ISA-1:0] DISK_MASK   = 16'hC000,
    localparam int                NUM_FRAMES  = NUM_ISA + NUM_LOW,
    localparam int                FRAME_W     = $clog2(NUM_FRAMES),
    localparam int                CNT_W       = $clog2(GAP_CLKS + 8) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stop_long_i,
    input  logic [1:0]            start_sel_i,
    inout  wire                   sirq_io,
    output logic [NUM_FRAMES-1:0] irq_req_o,
    output logic [NUM_ISA-1:0]    isa_fwd_o,
    output logic                  cyc_valid_o,
    output logic                  cont_mode_o
);

    logic               line_s;
    logic               drv_en;
    logic               drv_val;
    logic               samp;
    logic [FRAME_W-1:0] idx;
    logic               commit;

    assign line_s  = sirq_io;
    assign sirq_io = drv_en ? drv_val : 1'bz;

    sirq_frame_seq #(
        .GAP_CLKS  (GAP_CLKS),
        .NUM_FRAMES(NUM_FRAMES),
        .FRAME_W   (FRAME_W),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line_s),
        .stop_long_i(stop_long_i),
        .start_sel_i(start_sel_i),
        .drv_en_o   (drv_en),
        .drv_val_o  (drv_val),
        .samp_o     (samp),
        .idx_o      (idx),
        .commit_o   (commit),
        .cont_mode_o(cont_mode_o)
    );

    sirq_level_decode #(
        .NUM_ISA    (NUM_ISA),
        .NUM_LOW    (NUM_LOW),
        .IGNORE_MASK(IGNORE_MASK),
        .FRAME_W    (FRAME_W)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (line_s),
        .samp_i  (samp),
        .idx_i   (idx),
        .commit_i(commit),
        .lvl_o   (irq_req_o),
        .valid_o (cyc_valid_o)
    );

    assign isa_fwd_o = irq_req_o[NUM_ISA-1:0] & ~DISK_MASK;

    AST_FWD_UPDATES_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid_o |-> $stable(isa_fwd_o)); // R10
    AST_NO_DRIVE_IN_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
        samp |-> !drv_en); // R2

endmodule

// File: tb/sirq_host_test.sv
module sirq_host_test;

    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 16;
    localparam int NF         = 22;
    localparam int NUM_BUS    = 40;
    localparam int WD_LIMIT   = 100000;
    localparam int PULSE_REL  = 3;
    localparam logic [21:0] IGN = 22'h002101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stop_long = 1'b0;
    logic [1:0]  start_sel = 2'd0;
    logic        bdrv_en = 1'b0;
    logic        bdrv_val = 1'b1;
    wire         sirq_line;
    logic [21:0] irq_req;
    logic [15:0] isa_fwd;
    logic        cyc_valid;
    logic        cont_mode;

    pullup (sirq_line);
    assign sirq_line = bdrv_en ? bdrv_val : 1'bz;

    sirq_host uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_long_i(stop_long),
        .start_sel_i(start_sel),
        .sirq_io    (sirq_line),
        .irq_req_o  (irq_req),
        .isa_fwd_o  (isa_fwd),
        .cyc_valid_o(cyc_valid),
        .cont_mode_o(cont_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int start_w(input logic [1:0] sel);
        return (sel == 2'd0) ? 4 : (sel == 2'd1) ? 6 : 8;
    endfunction

    function automatic bit enc_low(input logic [21:0] q, input int f);
        return (f < 16) ? !q[f] : q[f];
    endfunction

    function automatic logic [21:0] exp_of(input logic [21:0] q);
        return q & ~IGN;
    endfunction

    int          cyc = 0;
    int          bstate = 0;
    int          lowrun = 0;
    int          run_start = 0;
    int          c0 = 0;
    int          phi_cyc = 0;
    int          done_cyc = 0;
    bit          active = 1'b0;
    bit          pulse_en = 1'b0;
    bit          mode_cont = 1'b1;
    logic [21:0] req = '0;
    logic [21:0] exp_lvl = '0;

    always @(negedge clk) begin
        logic l;
        int   rel, f, ph, diff, expd;
        bit   lowf;
        cyc++;
        l = sirq_line;
        if (cyc == 4) begin
            check(irq_req == '0 && isa_fwd == '0, "R11 outputs in reset", irq_req, 0);
            check(cyc_valid == 1'b0, "R11 strobe in reset", cyc_valid, 0);
            check(cont_mode == 1'b1, "R11 mode in reset", cont_mode, 1);
            check(l == 1'b1, "R11 line released in reset", l, 1);
        end else if (cyc == 5) begin
            rst_n   = 1'b1;
            phi_cyc = cyc - 1;
            active  = 1'b1;
        end else if (active) begin
            if (bstate == 0) begin
                if (cyc == phi_cyc + 1 && done_cyc > 0) begin
                    check(cyc_valid == 1'b0, "R10 strobe one clock", cyc_valid, 0);
                    check(irq_req == exp_lvl, "R10 levels held", irq_req, exp_lvl);
                end
                if (l == 1'b0) begin
                    if (lowrun == 0) run_start = cyc;
                    lowrun++;
                end else begin
                    if (lowrun >= 2) begin
                        check(lowrun == start_w(start_sel), "R1 start width", lowrun, start_w(start_sel));
                        diff = run_start - phi_cyc;
                        if (pulse_en && !mode_cont) begin
                            expd = PULSE_REL + 1;
                            check(diff == expd, "R9 quiet peripheral start", diff, expd);
                        end else begin
                            expd = GAP + 1;
                            if (pulse_en)
                                check(diff == expd, "R8 continuous ignores pulse", diff, expd);
                            else
                                check(diff == expd, "R1 idle gap", diff, expd);
                        end
                        bstate = 1;
                        c0     = cyc;
                    end
                    lowrun = 0;
                end
                if (pulse_en && cyc == phi_cyc + PULSE_REL) begin
                    bdrv_en  = 1'b1;
                    bdrv_val = 1'b0;
                end else begin
                    bdrv_en = 1'b0;
                end
            end else if (bstate == 1) begin
                rel = cyc - c0;
                bdrv_en = 1'b0;
                if (rel >= 2 && rel < 2 + 3*NF) begin
                    f    = (rel - 2) / 3;
                    ph   = (rel - 2) % 3;
                    lowf = enc_low(req, f);
                    if (ph == 0) begin
                        bdrv_en  = lowf;
                        bdrv_val = 1'b0;
                    end else if (ph == 1) begin
                        bdrv_en  = lowf;
                        bdrv_val = 1'b1;
                    end else if (!lowf && f < NF - 1 && ($urandom % 4) == 0) begin
                        bdrv_en  = 1'b1;
                        bdrv_val = 1'b0;
                    end
                    if (rel == 2 + 3*NF - 1) begin
                        bstate = 2;
                        lowrun = 0;
                    end
                end
            end else begin
                bdrv_en = 1'b0;
                if (l == 1'b0) begin
                    lowrun++;
                end else begin
                    expd = stop_long ? 3 : 2;
                    check(lowrun == expd, "R7 stop width", lowrun, expd);
                    check(cyc_valid == 1'b1, "R10 strobe at stop end", cyc_valid, 1);
                    check(((irq_req ^ exp_of(req)) & 22'h00FFFF & ~IGN) == '0,
                          "R2/R3 ISA levels", irq_req, exp_of(req));
                    check(((irq_req ^ req) & 22'h3F0000) == '0,
                          "R4 active-low levels", irq_req, exp_of(req));
                    check((irq_req & IGN) == '0, "R5 ignored frames", irq_req & IGN, 0);
                    check(isa_fwd == (exp_of(req) & 22'h003FFF), "R6 disk path vector",
                          isa_fwd, exp_of(req) & 22'h003FFF);
                    if (stop_long)
                        check(cont_mode == 1'b1, "R8 continuous mode", cont_mode, 1);
                    else
                        check(cont_mode == 1'b0, "R9 quiet mode", cont_mode, 0);
                    exp_lvl   = exp_of(req);
                    mode_cont = stop_long;
                    phi_cyc   = cyc;
                    done_cyc++;
                    bstate    = 0;
                    lowrun    = 0;
                    case (done_cyc)
                        1: begin req = '1; stop_long = 1'b1; start_sel = 2'd1; pulse_en = 1'b1; end
                        2: begin req = 22'h2AAAAA; stop_long = 1'b0; start_sel = 2'd2; pulse_en = 1'b1; end
                        3: begin req = 22'h155555; stop_long = 1'b1; start_sel = 2'd3; pulse_en = 1'b0; end
                        default: begin
                            req       = 22'($urandom);
                            stop_long = 1'($urandom % 2);
                            start_sel = 2'($urandom % 4);
                            pulse_en  = 1'($urandom % 2);
                        end
                    endcase
                end
            end
        end
    end

    initial begin
        int wd;
        void'($urandom(32'h5EED));
        wd = 0;
        while (done_cyc < NUM_BUS && wd < WD_LIMIT) begin
            @(posedge clk);
            wd++;
        end
        if (wd >= WD_LIMIT) check(1'b0, "watchdog expired", done_cyc, NUM_BUS);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule